// File: doc/BRIEF.md
# Host-Clocked Single-Wire Debug Bit Engine

This block times individual bits on a bidirectional, single-wire debug line. The host owns the bit clock: it opens every bit slot by pulling the line low. The engine carries the line through a two-flop synchronizer and detects the high-to-low transition on the synchronized value. From that point it counts system clock cycles to do one of three things:

- sample a bit sent by the host;
- leave the line released so that a 1 goes back to the host;
- hold the line low so that a 0 goes back to the host.

In both transmit cases the engine ends the bit with a single-cycle driven-high pulse, so the line recovers quickly before the host's next edge.

The surrounding debug logic picks the direction and the transmit value on `mode_tx` and `tx_bit`. Both are sampled in the cycle the edge is accepted. That logic then waits for `bit_done`, and in receive mode reads `rx_bit` alongside it. Byte framing, command decoding and memory access belong to other blocks. The pad is modelled open-drain style: `pin_oe` enables the driver and `pin_out` is the value driven.

Top module: `dbgbit_engine`

## Requirements
- R1: While reset is held and after it is released, `pin_oe`, `pin_out`, `bit_done` and `rx_bit` are all 0.
- R2: A high-to-low transition on `pin_in` is accepted two clock edges after it reaches the input flop. Cycle E0 is the first cycle after the third rising edge that follows the input change. The slot starts in E0.
- R3: Transmit 0 (`mode_tx`=1, `tx_bit`=0): `pin_oe`=1 and `pin_out`=0 for 9 cycles starting at E0. Then `pin_oe`=1 and `pin_out`=1 for exactly one cycle. Then `pin_oe`=0.
- R4: Transmit 1 (`mode_tx`=1, `tx_bit`=1): `pin_oe`=0 for 6 cycles starting at E0. Then `pin_oe`=1 and `pin_out`=1 for exactly one cycle. Then `pin_oe`=0.
- R5: Receive (`mode_tx`=0): `pin_oe` stays 0 for the whole slot. `rx_bit` takes the synchronized line level 12 cycles after E0, and it changes at no other time.
- R6: `bit_done` is 1 for exactly one cycle, the cycle after the last cycle of the slot. For receive that is E0+12. For transmit 1 it is E0+7. For transmit 0 it is E0+10.
- R7: High-to-low transitions that reach the engine while a slot is in progress do not start a new slot and do not change the timing of the current one.
- R8: `mode_tx` and `tx_bit` are used only in the cycle a slot is accepted. Changes to them during the slot have no effect on it.
- R9: If a high-to-low transition is accepted in the same cycle as `bit_done`, the next slot starts immediately, with that cycle as the next slot's acceptance cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every delay is counted in its cycles |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 1 | Raw level of the debug line, asynchronous to clk |
| mode_tx | input | 1 | 1 = transmit the next slot, 0 = receive it |
| tx_bit | input | 1 | Value to send when `mode_tx` is 1 |
| pin_out | output | 1 | Value driven onto the line; 1 only during the release pulse |
| pin_oe | output | 1 | Line driver enable; 1 only while driving low or during the pulse |
| rx_bit | output | 1 | Last bit sampled in receive mode |
| bit_done | output | 1 | One-cycle strobe that ends each slot |

## Verification
The end-of-slot strobe and acceptance of the host's next edge can land in the same cycle. That is the only point where one slot's teardown meets the next slot's setup. The bench provokes it by dropping the line again exactly when the first receive slot's sample window has closed, so that the second edge reaches the engine in the `bit_done` cycle. It then requires the first slot to report a 1 and a second strobe to arrive exactly thirteen cycles later carrying the 0 that the host is still holding. Late or lost acceptance moves or removes that second strobe.

// File: rtl/dbgbit_pkg.sv
package dbgbit_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RXWAIT = 3'd1,
    ST_TXREL  = 3'd2,
    ST_TXLOW  = 3'd3,
    ST_PULSE  = 3'd4
  } slot_st_t;

  // Counter width able to hold values 0..maxv.
  function automatic int cnt_width(input int maxv);
    return (maxv < 2) ? 1 : $clog2(maxv + 1);
  endfunction

  // Length in cycles of the first phase of a slot.
  function automatic int phase_len(input logic is_tx, input logic bitv,
                                   input int rx_n, input int tx1_n,
                                   input int tx0_n);
    if (!is_tx) return rx_n;
    return bitv ? tx1_n : tx0_n;
  endfunction

  // State entered when a slot is accepted.
  function automatic slot_st_t first_state(input logic is_tx, input logic bitv);
    if (!is_tx) return ST_RXWAIT;
    return bitv ? ST_TXREL : ST_TXLOW;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/dbgbit_sync.sv
module dbgbit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  output logic pin_s,
  output logic fall
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  // Line idles high, so the flops reset to 1 to avoid a spurious edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      prev_q <= 1'b1;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], pin_in};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign pin_s = sh_q[STAGES-1];
  assign fall  = prev_q & ~pin_s;

  p_fall_isolated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/dbgbit_timer.sv
module dbgbit_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/dbgbit_ctrl.sv
module dbgbit_ctrl
  import dbgbit_pkg::*;
#(
  parameter int RX_N  = 12,
  parameter int TX1_N = 6,
  parameter int TX0_N = 9,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fall,
  input  logic          pin_s,
  input  logic          mode_tx,
  input  logic          tx_bit,
  input  logic          tmr_zero,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          slot_start,
  output logic          busy,
  output logic          pin_out,
  output logic          pin_oe,
  output logic          rx_bit,
  output logic          bit_done
);
  slot_st_t state_q;
  logic     rx_q;
  logic     done_q;

  assign busy       = (state_q != ST_IDLE);
  assign slot_start = (state_q == ST_IDLE) && fall;
  assign tmr_load   = slot_start;
  assign tmr_val    = CW'(phase_len(mode_tx, tx_bit, RX_N, TX1_N, TX0_N) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rx_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE:   if (fall) state_q <= first_state(mode_tx, tx_bit);
        ST_RXWAIT: if (tmr_zero) begin
                     rx_q    <= pin_s;
                     done_q  <= 1'b1;
                     state_q <= ST_IDLE;
                   end
        ST_TXREL,
        ST_TXLOW:  if (tmr_zero) state_q <= ST_PULSE;
        ST_PULSE:  begin
                     done_q  <= 1'b1;
                     state_q <= ST_IDLE;
                   end
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign pin_oe   = (state_q == ST_TXLOW) || (state_q == ST_PULSE);
  assign pin_out  = (state_q == ST_PULSE);
  assign rx_bit   = rx_q;
  assign bit_done = done_q;

  p_done_after_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_done |-> $past(busy));
  p_rx_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_done |-> $stable(rx_bit));
endmodule

// File: rtl/dbgbit_engine.sv
module dbgbit_engine
  import dbgbit_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RX_N        = 12,
  parameter int TX1_N       = 6,
  parameter int TX0_N       = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  input  logic mode_tx,
  input  logic tx_bit,
  output logic pin_out,
  output logic pin_oe,
  output logic rx_bit,
  output logic bit_done
);
  localparam int CW = cnt_width(max3(RX_N, TX1_N, TX0_N));

  logic          pin_s;
  logic          fall;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_zero;
  logic          slot_start;
  logic          busy;

  dbgbit_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_s(pin_s), .fall(fall)
  );

  dbgbit_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .zero(tmr_zero)
  );

  dbgbit_ctrl #(.RX_N(RX_N), .TX1_N(TX1_N), .TX0_N(TX0_N), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .fall(fall), .pin_s(pin_s),
    .mode_tx(mode_tx), .tx_bit(tx_bit), .tmr_zero(tmr_zero),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .slot_start(slot_start),
    .busy(busy), .pin_out(pin_out), .pin_oe(pin_oe), .rx_bit(rx_bit),
    .bit_done(bit_done)
  );

  // A freshly loaded phase never reports expiry in the next cycle.
  p_load_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start |=> !tmr_zero);
  p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe && pin_out) |=> !(pin_oe && pin_out));
  p_low_then_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe && !pin_out) |=> pin_oe);
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_done |=> !bit_done);
  p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fall && !tmr_zero) |=> !slot_start);
endmodule

// File: tb/dbgbit_engine_tb.sv
module dbgbit_engine_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_low = 1'b0;
  logic mode_tx = 1'b0;
  logic tx_bit = 1'b0;
  logic pin_in;
  logic pin_out, pin_oe, rx_bit, bit_done;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   finished = 1'b0;

  always #5 clk = ~clk;

  // Wired line: low if the host pulls or the engine drives low.
  assign pin_in = host_low ? 1'b0 : (pin_oe ? pin_out : 1'b1);

  dbgbit_engine u_dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .mode_tx(mode_tx),
    .tx_bit(tx_bit), .pin_out(pin_out), .pin_oe(pin_oe), .rx_bit(rx_bit),
    .bit_done(bit_done)
  );

  task automatic chk(input string req, input string what, input int k,
                     input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at k=%0d: actual %b expected %b", req, what, k, act, exp);
    end
  endtask

  // Slot opened by a drop at negedge 0; E0 is seen at negedge 3.
  // Expected outputs at negedge k, restated from the requirements.
  function automatic logic e_oe(input bit tx, input bit b, input int k);
    if (!tx) return 1'b0;
    if (b) return (k == 9);
    return (k >= 3 && k <= 12);
  endfunction
  function automatic logic e_out(input bit tx, input bit b, input int k);
    if (!tx) return 1'b0;
    return b ? (k == 9) : (k == 12);
  endfunction
  function automatic int e_done_k(input bit tx, input bit b);
    if (!tx) return 15;
    return b ? 10 : 13;
  endfunction

  task automatic idle_gap();
    host_low = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  // One slot: host low for host_len cycles, optional 2-cycle glitch,
  // optional toggle of tx_bit/mode_tx at flip_at.
  task automatic slot(input string req, input bit tx, input bit b,
                      input int host_len, input int glitch_at,
                      input int flip_at, input logic exp_rx);
    logic rx_before;
    rx_before = rx_bit;
    mode_tx = tx;
    tx_bit  = b;
    for (int k = 0; k <= 30; k++) begin
      @(negedge clk);
      host_low = (k < host_len) || (glitch_at > 0 && k >= glitch_at && k < glitch_at + 2);
      if (k == flip_at) begin
        tx_bit  = ~tx_bit;
        mode_tx = ~mode_tx;
      end
      if (k >= 1) begin
        chk(req, "pin_oe", k, pin_oe, e_oe(tx, b, k));
        chk(req, "pin_out", k, pin_out, e_out(tx, b, k));
        chk("R6", "bit_done", k, bit_done, (k == e_done_k(tx, b)));
        if (!tx) chk("R5", "rx_bit", k, rx_bit,
                     (k >= e_done_k(tx, b)) ? exp_rx : rx_before);
      end
    end
    idle_gap();
  endtask

  task automatic reset_check();
    @(negedge clk);
    chk("R1", "pin_oe", 0, pin_oe, 1'b0);
    chk("R1", "bit_done", 0, bit_done, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "pin_oe", 0, pin_oe, 1'b0);
    chk("R1", "pin_out", 0, pin_out, 1'b0);
    chk("R1", "bit_done", 0, bit_done, 1'b0);
    chk("R1", "rx_bit", 0, rx_bit, 1'b0);
  endtask

  // R9: second drop timed so its edge is accepted in the strobe cycle.
  task automatic back_to_back();
    mode_tx = 1'b0;
    for (int k = 0; k <= 40; k++) begin
      @(negedge clk);
      host_low = (k < 4) || (k >= 13 && k < 33);
      if (k >= 1) begin
        chk("R9", "bit_done", k, bit_done, (k == 15 || k == 28));
        if (k == 15) chk("R9", "rx_bit first", k, rx_bit, 1'b1);
        if (k == 28) chk("R9", "rx_bit second", k, rx_bit, 1'b0);
      end
    end
    idle_gap();
  endtask

  initial begin
    reset_check();
    slot("R3", 1'b1, 1'b0, 2, 0, -1, 1'b0);   // transmit 0
    slot("R4", 1'b1, 1'b1, 2, 0, -1, 1'b0);   // transmit 1
    slot("R5", 1'b0, 1'b0, 20, 0, -1, 1'b0);  // receive 0, host holds long
    slot("R5", 1'b0, 1'b0, 4, 0, -1, 1'b1);   // receive 1, short pulse
    slot("R7", 1'b0, 1'b0, 4, 6, -1, 1'b1);   // glitch mid-slot ignored
    slot("R7", 1'b1, 1'b0, 2, 5, -1, 1'b0);   // glitch during drive-low
    slot("R8", 1'b1, 1'b0, 2, 0, 5, 1'b0);    // inputs flip mid-slot
    slot("R8", 1'b0, 1'b0, 20, 0, 4, 1'b0);   // receive, mode flips mid-slot
    slot("R2", 1'b1, 1'b1, 2, 0, -1, 1'b0);   // acceptance latency
    back_to_back();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule